// File: doc/BRIEF.md
# Upstream-Port L1 Power-State Controller

This block decides when a switch upstream port asks its link partner for the L1 low-power link state, and when it leaves that state. It watches the whole switch partition and the port's own traffic. Every downstream port that still matters must already sit in L1. The port must have nothing waiting to transmit, and its replay buffer must be empty. The receiver must have been quiet for a programmed number of cycles. Flow-control credits must cover the largest packet of every type. When all of these hold, the block raises an L1 request and waits for the partner's verdict.

An acknowledgement moves the port into L1. A refusal returns the port to L0 and produces a one-cycle strobe that tells the transmitter to try L0s instead. While in L1, the block asks for exit when a TLP becomes pending or when any downstream port begins its own exit. The exit request follows a downstream exit within a bounded number of cycles. Physical signalling, DLLP coding and credit bookkeeping live elsewhere and reach the block as plain levels and strobes.

Top module: `l1pm_ctrl`

## Requirements
- R1: While `aspm_l1_en` is 0 the block never leaves L0 on its own, and an outstanding request is withdrawn.
- R2: Entry needs every downstream port to show at least one of these bits: in L1, in D3, or link down. A port that is in D3 or link down is left out of the L1 check.
- R3: Entry is blocked while `tlp_pending` is 1, while `dllp_pending` is 1, or while `replay_empty` is 0.
- R4: Entry needs `IDLE_CYC` clock edges with no `rx_pkt` strobe. After a strobe sampled at edge k, with every other condition met, `l1_req` is still 0 after edge k+4 and is 1 after edge k+5 when `IDLE_CYC` is 4.
- R5: Entry needs every credit type to be covered. Type i occupies bits [i*CW +: CW] of the credit buses, with i = 0 for posted, 1 for non-posted and 2 for completion. For each type the header credit must be at least the header need, and the data credit at least the data need.
- R6: Once every condition holds, `l1_req` rises one edge later and stays high until the partner answers or a condition drops. `pwr_state` encodes 0 for L0, 1 for requesting and 2 for L1. A `partner_ack` sampled while requesting moves `pwr_state` to 2 and lowers `l1_req`.
- R7: A `partner_nak` sampled while requesting returns the port to L0, raises `l0s_try` for exactly one cycle, and restarts the idle interval.
- R8: If any entry condition is false while the request is outstanding, the port returns to L0 at the next edge. This happens even when `partner_ack` arrives in the same cycle.
- R9: In L1, a pending TLP or any bit of `ds_exit_start` moves the port to L0 at the next edge and pulses `l1_exit_req` for one cycle.
- R10: `l1_exit_req` follows a downstream exit start seen in L1 within `EXIT_MAX` cycles.
- R11: Leaving L1 restarts the idle interval, so a new request needs a full `IDLE_CYC` quiet period.
- R12: `l1_req`, `l0s_try` and `l1_exit_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aspm_l1_en | input | 1 | L1 ASPM enable |
| ds_in_l1 | input | N_DS | Downstream port reports L1 |
| ds_in_d3 | input | N_DS | Downstream port is in D3 |
| ds_link_down | input | N_DS | Downstream port link is down |
| ds_exit_start | input | N_DS | Downstream port begins L1 exit (strobe) |
| tlp_pending | input | 1 | TLP waiting for transmission |
| dllp_pending | input | 1 | DLLP waiting for transmission |
| replay_empty | input | 1 | Replay buffer is empty |
| rx_pkt | input | 1 | A TLP or DLLP was received (strobe) |
| hdr_cred | input | 3*CW | Header credits per type |
| data_cred | input | 3*CW | Data credits per type |
| hdr_need | input | 3*CW | Header credits needed for the largest packet per type |
| data_need | input | 3*CW | Data credits needed for the largest packet per type |
| partner_ack | input | 1 | Partner accepts L1 |
| partner_nak | input | 1 | Partner rejects L1 |
| l1_req | output | 1 | L1 request to partner |
| l0s_try | output | 1 | One-cycle strobe: attempt L0s |
| pwr_state | output | 2 | Link power state (0 L0, 1 requesting, 2 L1) |
| l1_exit_req | output | 1 | One-cycle strobe: begin L1 exit |

## Verification
The hardest case to reach is the entry condition itself. It is the AND of a 12-bit partition pattern, six credit comparisons, three traffic flags and a timer. Each factor only matters once all the others are true. The bench first lets the idle timer saturate with the enable held low. It then applies each partition pattern or credit value together with the enable for exactly one edge, reads `l1_req`, and drops the enable to force a withdrawal. This lets it sweep all 4096 partition patterns and every credit value without reaching L1. Exit, rejection and the restart of the idle interval are reached by first completing a real handshake.

// File: rtl/l1pm_pkg.sv
package l1pm_pkg;

    typedef enum logic [1:0] {
        PS_L0  = 2'd0,
        PS_REQ = 2'd1,
        PS_L1  = 2'd2
    } pm_state_e;

    typedef struct packed {
        pm_state_e st;
        logic      l0s;
        logic      ex;
    } pm_ctl_t;

    localparam int N_CRED_TYPES = 3;

endpackage

// File: rtl/l1pm_idle_timer.sv
module l1pm_idle_timer #(
    parameter int IDLE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pkt,
    input  logic rearm,
    output logic idle_ok
);
    localparam int CNTW = $clog2(IDLE_CYC + 1);
    localparam logic [CNTW-1:0] CMAX = CNTW'(IDLE_CYC);

    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (rx_pkt || rearm)
            cnt_d = '0;
        else if (cnt_q != CMAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle_ok = (cnt_q == CMAX);

    // R4: a received packet restarts the quiet interval
    assert_rx_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pkt |=> !idle_ok);
    // R11: re-arming clears the quiet interval
    assert_rearm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (cnt_q == '0));
endmodule

// File: rtl/l1pm_credit_gate.sv
module l1pm_credit_gate #(
    parameter int CW = 8
) (
    input  logic [3*CW-1:0] hdr_cred,
    input  logic [3*CW-1:0] data_cred,
    input  logic [3*CW-1:0] hdr_need,
    input  logic [3*CW-1:0] data_need,
    output logic            cred_ok
);
    import l1pm_pkg::*;
    logic [N_CRED_TYPES-1:0] type_ok;

    for (genvar i = 0; i < N_CRED_TYPES; i++) begin : g_type
        assign type_ok[i] = (hdr_cred[i*CW +: CW]  >= hdr_need[i*CW +: CW]) &&
                            (data_cred[i*CW +: CW] >= data_need[i*CW +: CW]);
    end

    assign cred_ok = &type_ok;
endmodule

// File: rtl/l1pm_partition_gate.sv
module l1pm_partition_gate #(
    parameter int N_DS = 4
) (
    input  logic [N_DS-1:0] ds_in_l1,
    input  logic [N_DS-1:0] ds_in_d3,
    input  logic [N_DS-1:0] ds_link_down,
    output logic            part_ok
);
    logic [N_DS-1:0] port_ok;

    for (genvar p = 0; p < N_DS; p++) begin : g_port
        // a port in D3 or with its link down does not hold up entry
        assign port_ok[p] = ds_in_l1[p] | ds_in_d3[p] | ds_link_down[p];
    end

    assign part_ok = &port_ok;
endmodule

// File: rtl/l1pm_ctrl.sv
module l1pm_ctrl
    import l1pm_pkg::*;
#(
    parameter int N_DS     = 4,
    parameter int CW       = 8,
    parameter int IDLE_CYC = 1000,
    parameter int EXIT_MAX = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            aspm_l1_en,
    input  logic [N_DS-1:0] ds_in_l1,
    input  logic [N_DS-1:0] ds_in_d3,
    input  logic [N_DS-1:0] ds_link_down,
    input  logic [N_DS-1:0] ds_exit_start,
    input  logic            tlp_pending,
    input  logic            dllp_pending,
    input  logic            replay_empty,
    input  logic            rx_pkt,
    input  logic [3*CW-1:0] hdr_cred,
    input  logic [3*CW-1:0] data_cred,
    input  logic [3*CW-1:0] hdr_need,
    input  logic [3*CW-1:0] data_need,
    input  logic            partner_ack,
    input  logic            partner_nak,
    output logic            l1_req,
    output logic            l0s_try,
    output logic [1:0]      pwr_state,
    output logic            l1_exit_req
);
    localparam int LATW = $clog2(EXIT_MAX + 2);

    logic    idle_ok, cred_ok, part_ok, entry_ok, rearm, exit_trig;
    pm_ctl_t ctl_d, ctl_q;

    l1pm_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
        .clk(clk), .rst_n(rst_n), .rx_pkt(rx_pkt), .rearm(rearm), .idle_ok(idle_ok)
    );

    l1pm_credit_gate #(.CW(CW)) u_cred (
        .hdr_cred(hdr_cred), .data_cred(data_cred),
        .hdr_need(hdr_need), .data_need(data_need), .cred_ok(cred_ok)
    );

    l1pm_partition_gate #(.N_DS(N_DS)) u_part (
        .ds_in_l1(ds_in_l1), .ds_in_d3(ds_in_d3), .ds_link_down(ds_link_down),
        .part_ok(part_ok)
    );

    assign entry_ok  = aspm_l1_en && part_ok && !tlp_pending && !dllp_pending &&
                       replay_empty && idle_ok && cred_ok;
    assign exit_trig = tlp_pending || (|ds_exit_start);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.l0s = 1'b0;
        ctl_d.ex  = 1'b0;
        rearm     = 1'b0;
        unique case (ctl_q.st)
            PS_L0: begin
                if (entry_ok) ctl_d.st = PS_REQ;
            end
            PS_REQ: begin
                if (!entry_ok) begin
                    ctl_d.st = PS_L0;
                end else if (partner_ack) begin
                    ctl_d.st = PS_L1;
                end else if (partner_nak) begin
                    ctl_d.st  = PS_L0;
                    ctl_d.l0s = 1'b1;
                    rearm     = 1'b1;
                end
            end
            PS_L1: begin
                if (exit_trig) begin
                    ctl_d.st = PS_L0;
                    ctl_d.ex = 1'b1;
                    rearm    = 1'b1;
                end
            end
            default: ctl_d.st = PS_L0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: PS_L0, l0s: 1'b0, ex: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign l1_req      = (ctl_q.st == PS_REQ);
    assign l0s_try     = ctl_q.l0s;
    assign l1_exit_req = ctl_q.ex;
    assign pwr_state   = ctl_q.st;

    // exit latency watch: counts cycles from a downstream exit start seen in L1
    logic            lat_pend_q;
    logic [LATW-1:0] lat_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_pend_q <= 1'b0;
            lat_cnt_q  <= '0;
        end else if (l1_exit_req) begin
            lat_pend_q <= 1'b0;
            lat_cnt_q  <= '0;
        end else if (lat_pend_q || (ctl_q.st == PS_L1 && |ds_exit_start)) begin
            lat_pend_q <= 1'b1;
            if (lat_cnt_q != {LATW{1'b1}}) lat_cnt_q <= lat_cnt_q + 1'b1;
        end
    end

    assert_exit_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lat_cnt_q <= LATW'(EXIT_MAX));
    assert_ds_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2 && |ds_exit_start) |=> (l1_exit_req && pwr_state == 2'd0));
    assert_enable_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!aspm_l1_en && pwr_state == 2'd0) |=> (pwr_state == 2'd0));
    assert_withdraw_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_req && (dllp_pending || !aspm_l1_en)) |=> (pwr_state == 2'd0));
    assert_l1_via_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0) |=> (pwr_state != 2'd2));
    assert_nak_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        l0s_try |=> !l0s_try);
    assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({l1_req, l0s_try, l1_exit_req}));
endmodule

// File: tb/sim_l1pm_ctrl.sv
module sim_l1pm_ctrl;
    localparam int N  = 4;
    localparam int CW = 4;
    localparam int IC = 4;
    localparam int EM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [N-1:0] l1s = '1, d3s = '0, lds = '0, dxs = '0;
    logic tlp = 1'b0, dllp = 1'b0, rep = 1'b1, rx = 1'b0, ack = 1'b0, nak = 1'b0;
    logic [3*CW-1:0] hc = '1, dc = '1, hn = '0, dn = '0;
    logic l1_req, l0s_try, l1_exit_req;
    logic [1:0] pwr;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    l1pm_ctrl #(.N_DS(N), .CW(CW), .IDLE_CYC(IC), .EXIT_MAX(EM)) u0 (
        .clk(clk), .rst_n(rst_n), .aspm_l1_en(en), .ds_in_l1(l1s), .ds_in_d3(d3s),
        .ds_link_down(lds), .ds_exit_start(dxs), .tlp_pending(tlp), .dllp_pending(dllp),
        .replay_empty(rep), .rx_pkt(rx), .hdr_cred(hc), .data_cred(dc), .hdr_need(hn),
        .data_need(dn), .partner_ack(ack), .partner_nak(nak), .l1_req(l1_req),
        .l0s_try(l0s_try), .pwr_state(pwr), .l1_exit_req(l1_exit_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one edge, then sample 1 ns after it; inputs change at negedge
    task automatic step();
        @(posedge clk); #1;
    endtask
    task automatic drv();
        @(negedge clk);
    endtask
    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // one-edge probe of the entry condition; returns to L0 afterwards
    task automatic probe(input string req, input bit exp);
        drv(); en = 1'b1;
        step();
        chk(req, l1_req, exp);
        drv(); en = 1'b0;
        step();
        chk(req, pwr, 0);
    endtask

    task automatic reach_req();
        drv(); en = 1'b1;
        step();
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1;
        chk("R6 reset pwr", pwr, 0);
        chk("R12 reset strobes", {l1_req, l0s_try, l1_exit_req}, 0);
        drv(); rst_n = 1'b1;
        // R1: disabled, conditions otherwise all good
        steps(20);
        chk("R1 stays L0 while disabled", pwr, 0);
        chk("R1 no request", l1_req, 0);

        // R4: exact idle interval after a strobe
        drv(); rx = 1'b1; en = 1'b1;
        step();             // edge k samples strobe
        drv(); rx = 1'b0;
        steps(IC);
        chk("R4 not yet after k+4", l1_req, 0);
        step();
        chk("R4 request after k+5", l1_req, 1);
        drv(); en = 1'b0;
        step();
        chk("R1 withdraw on disable", pwr, 0);

        // R2: every partition pattern
        for (int v = 0; v < (1 << (3*N)); v++) begin
            logic [N-1:0] a, b, c;
            a = v[N-1:0]; b = v[2*N-1:N]; c = v[3*N-1:2*N];
            drv(); l1s = a; d3s = b; lds = c;
            probe("R2 partition", &(a | b | c));
        end
        drv(); l1s = '1; d3s = '0; lds = '0;

        // R5: each type, header and data, every credit value against need 7
        for (int t = 0; t < 3; t++) begin
            for (int cv = 0; cv < (1 << CW); cv++) begin
                drv(); hc = '1; dc = '1; hn = '0; dn = '0;
                hn[t*CW +: CW] = CW'(7); hc[t*CW +: CW] = CW'(cv);
                probe("R5 header credit", cv >= 7);
                drv(); hc = '1; hn = '0;
                dn[t*CW +: CW] = CW'(7); dc[t*CW +: CW] = CW'(cv);
                probe("R5 data credit", cv >= 7);
            end
        end
        drv(); hc = '1; dc = '1; hn = '0; dn = '0;

        // R3: traffic and replay blockers
        drv(); tlp = 1'b1;  probe("R3 tlp pending", 1'b0);
        drv(); tlp = 1'b0; dllp = 1'b1; probe("R3 dllp pending", 1'b0);
        drv(); dllp = 1'b0; rep = 1'b0; probe("R3 replay busy", 1'b0);
        drv(); rep = 1'b1; probe("R3 all clear", 1'b1);

        // R6: request holds, then ack enters L1
        reach_req();
        steps(3);
        chk("R6 request held", l1_req, 1);
        chk("R6 pwr requesting", pwr, 1);
        drv(); ack = 1'b1;
        step();
        drv(); ack = 1'b0;
        chk("R6 pwr L1", pwr, 2);
        chk("R6 request dropped", l1_req, 0);

        // R9/R11: exit on TLP, then full quiet interval again
        drv(); tlp = 1'b1;
        step();
        chk("R9 exit strobe on tlp", l1_exit_req, 1);
        chk("R9 pwr L0 after exit", pwr, 0);
        drv(); tlp = 1'b0;
        step();
        chk("R9 exit strobe one cycle", l1_exit_req, 0);
        steps(IC - 1);
        chk("R11 no request before interval", l1_req, 0);
        step();
        chk("R11 request after interval", l1_req, 1);

        // R9/R10: exit on each downstream port's exit start
        for (int p = 0; p < N; p++) begin
            drv(); ack = 1'b1;
            step();
            drv(); ack = 1'b0;
            chk("R6 in L1", pwr, 2);
            drv(); dxs = '0; dxs[p] = 1'b1;
            step();
            drv(); dxs = '0;
            chk("R10 exit within bound", l1_exit_req, 1);
            chk("R9 pwr L0", pwr, 0);
            steps(IC + 1);
            chk("R11 re-request", l1_req, 1);
        end

        // R7: rejection
        drv(); nak = 1'b1;
        step();
        drv(); nak = 1'b0;
        chk("R7 l0s strobe", l0s_try, 1);
        chk("R7 back to L0", pwr, 0);
        step();
        chk("R7 strobe one cycle", l0s_try, 0);
        steps(IC - 1);
        chk("R7 interval restarted", l1_req, 0);
        step();
        chk("R7 request after interval", l1_req, 1);

        // R8: condition drop beats a simultaneous ack
        drv(); dllp = 1'b1; ack = 1'b1;
        step();
        drv(); dllp = 1'b0; ack = 1'b0;
        chk("R8 withdrawn to L0", pwr, 0);
        chk("R12 no strobe on withdraw", {l0s_try, l1_exit_req}, 0);
        step();
        chk("R8 re-request", l1_req, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule